// File: doc/BRIEF.md
# AXI4-Lite Register-Bus Bridge

This block sits on the slave side of an AXI4-Lite port and converts each single-beat access into a simple register-bus exchange for user logic. The address of a write or read is compared against a configurable window. Inside the window, the word offset selects one register. That register gets its own active-high write or read chip enable, and the write data and byte enables are presented next to it. The bridge then holds the enable until the user logic acknowledges. It returns OKAY, or SLVERR when the user logic flags an error.

If no acknowledge arrives within a bounded number of cycles, the bridge completes the access by itself with SLVERR. An access that decodes to no register follows the same path. A read completed this way returns zero. Only one access is outstanding at a time, so the user logic never sees overlapping requests.

Top module: `axil_regbus_bridge`

## Requirements
- R1: While reset is held and just after it is released, BVALID, RVALID, both chip-enable vectors, BRESP, RRESP and RDATA are all zero.
- R2: AWREADY and WREADY rise together, only while the bridge is idle and both AWVALID and WVALID are high. No ready is given while an access is in its data phase or its response is pending.
- R3: A write to BASE + 4*k, with k below NUM_REGS, drives exactly one write chip enable, bit NUM_REGS-1-k. The leftmost bit is offset 0, so with four registers offset 0x4 gives 0100. The enable stays high from the cycle after the handshake until the acknowledge or timeout edge.
- R4: A read decodes the same way onto the read chip-enable vector. Write and read enables are never high together.
- R5: During a write data phase, the register-bus data and byte enables equal the captured WDATA and WSTRB and hold steady. Byte-enable bit k qualifies data bits 8k+7..8k.
- R6: A write acknowledge on a clock edge ends the data phase. BVALID is high from the next cycle, with BRESP 00 (OKAY), or 10 (SLVERR) if the error input was high on that edge.
- R7: A read acknowledge on a clock edge captures the register-bus read data into RDATA. RVALID is high from the next cycle, with RRESP 00, or 10 if the error input was high on that edge.
- R8: If no acknowledge comes within TIMEOUT data-phase cycles (default 8), the bridge ends the access with SLVERR and a read returns RDATA zero. An acknowledge in the final cycle still completes normally.
- R9: An address outside [BASE, HIGH], or at an offset of NUM_REGS words or more, raises no chip enable. It ends with SLVERR after the timeout and leaves every register unchanged.
- R10: BVALID and RVALID stay high, with the response and data unchanged, until BREADY or RREADY is seen.
- R11: When a full write (AWVALID and WVALID) and a read address are both offered to an idle bridge, the write is accepted and ARREADY stays low.
- R12: Reset is active low and synchronous: lowering it changes nothing until the next rising edge, and after that edge an access in progress is dropped.
- R13: An acknowledge of the wrong kind, a read acknowledge during a write or the reverse, is ignored. The access times out with SLVERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstn | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| reg_wr_ce | output | NUM_REGS | One-hot write chip enables, offset 0 leftmost |
| reg_rd_ce | output | NUM_REGS | One-hot read chip enables, offset 0 leftmost |
| reg_wdata | output | DATA_W | Write data to user logic |
| reg_be | output | DATA_W/8 | Byte enables to user logic |
| reg_rdata | input | DATA_W | Read data from user logic |
| reg_wr_ack | input | 1 | Write acknowledge from user logic |
| reg_rd_ack | input | 1 | Read acknowledge from user logic |
| reg_err | input | 1 | Error flag, qualified by an acknowledge |

## Verification
The assertions assume that the user logic acknowledges only while one of its chip enables is high. They also assume a single-cycle acknowledge that drops once the enable falls. The bench's register stub obeys both rules and never asserts an acknowledge or error flag on its own. The master side keeps AWVALID and WVALID paired and never changes an address while it waits for ready. Random addresses cover valid registers and out-of-range offsets, with latencies short enough to finish or deliberately missing so that the timeout path runs.

// File: rtl/axil_rb_pkg.sv
package axil_rb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WPH,
      ST_RPH,
      ST_WRSP,
      ST_RRSP
   } rb_state_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axil_rb_decode.sv
module axil_rb_decode #(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_REGS  = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000_0000,
   parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h4000_00FF
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel
);
   logic              in_win;
   logic [ADDR_W-1:0] off_word;

   assign in_win   = (addr >= BASE_ADDR) && (addr <= HIGH_ADDR);
   assign off_word = (addr - BASE_ADDR) >> 2;

   // register k (byte offset 4k) owns the k-th bit counted from the left
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
      assign sel[NUM_REGS-1-k] = in_win && (off_word == ADDR_W'(k));
   end
endmodule

// File: rtl/axil_rb_ctrl.sv
module axil_rb_ctrl
   import axil_rb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TIMEOUT = 8
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              awvalid,
   input  logic              wvalid,
   input  logic              arvalid,
   input  logic              bready,
   input  logic              rready,
   input  logic              hit,
   input  logic              wr_ack,
   input  logic              rd_ack,
   input  logic              user_err,
   input  logic [DATA_W-1:0] user_rdata,
   output logic              awready,
   output logic              wready,
   output logic              arready,
   output logic              bvalid,
   output logic              rvalid,
   output logic [1:0]        bresp,
   output logic [1:0]        rresp,
   output logic [DATA_W-1:0] rdata,
   output logic              wph,
   output logic              rph,
   output logic              take_w,
   output logic              take_r
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam int RUN_W = CNT_W + 1;

   rb_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        bresp_q, rresp_q;
   logic [DATA_W-1:0] rdata_q;
   logic              expired, ack_w, ack_r;

   assign take_w  = (st_q == ST_IDLE) && awvalid && wvalid;
   assign take_r  = (st_q == ST_IDLE) && arvalid && !(awvalid && wvalid);
   assign expired = (cnt_q == CNT_W'(TIMEOUT - 1));
   assign ack_w   = wr_ack && hit;
   assign ack_r   = rd_ack && hit;

   always_ff @(posedge clk) begin
      if (!rstn) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         bresp_q <= RESP_OKAY;
         rresp_q <= RESP_OKAY;
         rdata_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (take_w)      st_q <= ST_WPH;
               else if (take_r) st_q <= ST_RPH;
            end
            ST_WPH: begin
               if (ack_w) begin
                  st_q    <= ST_WRSP;
                  bresp_q <= user_err ? RESP_SLVERR : RESP_OKAY;
               end else if (expired) begin
                  st_q    <= ST_WRSP;
                  bresp_q <= RESP_SLVERR;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RPH: begin
               if (ack_r) begin
                  st_q    <= ST_RRSP;
                  rdata_q <= user_rdata;
                  rresp_q <= user_err ? RESP_SLVERR : RESP_OKAY;
               end else if (expired) begin
                  st_q    <= ST_RRSP;
                  rdata_q <= '0;
                  rresp_q <= RESP_SLVERR;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WRSP: if (bready) st_q <= ST_IDLE;
            ST_RRSP: if (rready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign awready = take_w;
   assign wready  = take_w;
   assign arready = take_r;
   assign wph     = (st_q == ST_WPH);
   assign rph     = (st_q == ST_RPH);
   assign bvalid  = (st_q == ST_WRSP);
   assign rvalid  = (st_q == ST_RRSP);
   assign bresp   = bresp_q;
   assign rresp   = rresp_q;
   assign rdata   = rdata_q;

   // checker counter: length of the current data phase
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rstn)                          run_q <= '0;
      else if (!(wph || rph))             run_q <= '0;
      else if (run_q != {RUN_W{1'b1}})    run_q <= run_q + 1'b1;
   end

   // R2
   hs_pair_chk: assert property (@(posedge clk) disable iff (!rstn)
      awready |-> (wready && awvalid && wvalid && !arready));
   // R2
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstn)
      (wph || rph || bvalid || rvalid) |-> !(awready || arready));
   // R10
   bhold_chk: assert property (@(posedge clk) disable iff (!rstn)
      (bvalid && !bready) |=> (bvalid && $stable(bresp)));
   // R10
   rhold_chk: assert property (@(posedge clk) disable iff (!rstn)
      (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rdata)));
   // R6
   wack_resp_chk: assert property (@(posedge clk) disable iff (!rstn)
      (wph && wr_ack && hit) |=>
         (bvalid && bresp == ($past(user_err) ? RESP_SLVERR : RESP_OKAY)));
   // R8
   phase_len_chk: assert property (@(posedge clk) disable iff (!rstn)
      (wph || rph) |-> (run_q < RUN_W'(TIMEOUT)));
endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge #(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                NUM_REGS  = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000_0000,
   parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h4000_00FF,
   parameter int                TIMEOUT   = 8
) (
   input  logic                  clk,
   input  logic                  rstn,
   input  logic [ADDR_W-1:0]     s_awaddr,
   input  logic                  s_awvalid,
   output logic                  s_awready,
   input  logic [DATA_W-1:0]     s_wdata,
   input  logic [DATA_W/8-1:0]   s_wstrb,
   input  logic                  s_wvalid,
   output logic                  s_wready,
   output logic [1:0]            s_bresp,
   output logic                  s_bvalid,
   input  logic                  s_bready,
   input  logic [ADDR_W-1:0]     s_araddr,
   input  logic                  s_arvalid,
   output logic                  s_arready,
   output logic [DATA_W-1:0]     s_rdata,
   output logic [1:0]            s_rresp,
   output logic                  s_rvalid,
   input  logic                  s_rready,
   output logic [NUM_REGS-1:0]   reg_wr_ce,
   output logic [NUM_REGS-1:0]   reg_rd_ce,
   output logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W/8-1:0]   reg_be,
   input  logic [DATA_W-1:0]     reg_rdata,
   input  logic                  reg_wr_ack,
   input  logic                  reg_rd_ack,
   input  logic                  reg_err
);
   localparam int                STRB_W = DATA_W / 8;
   localparam logic [ADDR_W-1:0] SPAN   = HIGH_ADDR - BASE_ADDR;

   // elaboration-time parameter checks
   if (NUM_REGS < 1) begin : g_bad_regs
      $error("NUM_REGS must be at least 1");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (TIMEOUT < 1) begin : g_bad_timeout
      $error("TIMEOUT must be at least 1");
   end
   if (HIGH_ADDR < BASE_ADDR || SPAN < ADDR_W'('hFF)) begin : g_bad_window
      $error("address window must span at least 0x100 bytes");
   end
   if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
      $error("BASE_ADDR must be word aligned");
   end
   if (ADDR_W'(NUM_REGS * 4 - 1) > SPAN) begin : g_bad_fit
      $error("registers do not fit inside the window");
   end

   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [STRB_W-1:0]   wstrb_q;
   logic [NUM_REGS-1:0] sel;
   logic                hit, wph, rph, take_w, take_r;

   always_ff @(posedge clk) begin
      if (!rstn) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wstrb_q <= '0;
      end else if (take_w) begin
         addr_q  <= s_awaddr;
         wdata_q <= s_wdata;
         wstrb_q <= s_wstrb;
      end else if (take_r) begin
         addr_q  <= s_araddr;
      end
   end

   axil_rb_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .BASE_ADDR(BASE_ADDR),
      .HIGH_ADDR(HIGH_ADDR)
   ) u_decode (
      .addr(addr_q),
      .sel (sel)
   );

   assign hit = |sel;

   axil_rb_ctrl #(
      .DATA_W (DATA_W),
      .TIMEOUT(TIMEOUT)
   ) u_ctrl (
      .clk       (clk),
      .rstn      (rstn),
      .awvalid   (s_awvalid),
      .wvalid    (s_wvalid),
      .arvalid   (s_arvalid),
      .bready    (s_bready),
      .rready    (s_rready),
      .hit       (hit),
      .wr_ack    (reg_wr_ack),
      .rd_ack    (reg_rd_ack),
      .user_err  (reg_err),
      .user_rdata(reg_rdata),
      .awready   (s_awready),
      .wready    (s_wready),
      .arready   (s_arready),
      .bvalid    (s_bvalid),
      .rvalid    (s_rvalid),
      .bresp     (s_bresp),
      .rresp     (s_rresp),
      .rdata     (s_rdata),
      .wph       (wph),
      .rph       (rph),
      .take_w    (take_w),
      .take_r    (take_r)
   );

   assign reg_wr_ce = wph ? sel : '0;
   assign reg_rd_ce = rph ? sel : '0;
   assign reg_wdata = wdata_q;
   assign reg_be    = wstrb_q;

   // R3
   wce_onehot_chk: assert property (@(posedge clk) disable iff (!rstn)
      $onehot0(reg_wr_ce));
   // R4
   rce_onehot_chk: assert property (@(posedge clk) disable iff (!rstn)
      $onehot0(reg_rd_ce));
   // R4
   ce_excl_chk: assert property (@(posedge clk) disable iff (!rstn)
      !((|reg_wr_ce) && (|reg_rd_ce)));
   // R5
   wpath_stable_chk: assert property (@(posedge clk) disable iff (!rstn)
      ((|reg_wr_ce) && $past(|reg_wr_ce)) |->
         ($stable(reg_wdata) && $stable(reg_be) && $stable(reg_wr_ce)));
endmodule

// File: tb/axil_regbus_bridge_tb.sv
module axil_regbus_bridge_tb;
   localparam int          NREG = 4;
   localparam int          TMO  = 8;
   localparam logic [31:0] BASE = 32'h4000_0000;
   localparam logic [31:0] HIGH = 32'h4000_00FF;

   logic        clk = 1'b0;
   logic        rstn = 1'b0;
   logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
   logic [3:0]  s_wstrb = '0;
   logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
   logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]  s_bresp, s_rresp;
   logic [31:0] s_rdata;
   logic [NREG-1:0] reg_wr_ce, reg_rd_ce;
   logic [31:0] reg_wdata, reg_rdata;
   logic [3:0]  reg_be;
   logic        reg_wr_ack, reg_rd_ack, reg_err;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   axil_regbus_bridge #(
      .ADDR_W(32), .DATA_W(32), .NUM_REGS(NREG),
      .BASE_ADDR(BASE), .HIGH_ADDR(HIGH), .TIMEOUT(TMO)
   ) u_dut (
      .clk(clk), .rstn(rstn),
      .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
      .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
      .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
      .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
      .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
      .reg_wr_ce(reg_wr_ce), .reg_rd_ce(reg_rd_ce), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .reg_rdata(reg_rdata), .reg_wr_ack(reg_wr_ack),
      .reg_rd_ack(reg_rd_ack), .reg_err(reg_err)
   );

   // ---------------- register stub ----------------
   int          stub_lat = 0;
   bit          stub_noack = 0, stub_err = 0, stub_wrong = 0;
   logic [31:0] stub_regs [NREG];
   int          wc = 0, ce_cyc = 0;
   logic [NREG-1:0] seen_w = '0, seen_r = '0;

   function automatic int ce_idx(input logic [NREG-1:0] ce);
      for (int k = 0; k < NREG; k++) if (ce[NREG-1-k]) return k;
      return 0;
   endfunction

   initial for (int k = 0; k < NREG; k++) stub_regs[k] = '0;

   always_comb reg_rdata = stub_regs[ce_idx(reg_rd_ce)];

   always @(posedge clk) begin
      if (s_awready || s_arready) begin
         seen_w <= '0; seen_r <= '0; ce_cyc <= 0;
      end
      if (!rstn) begin
         reg_wr_ack <= 0; reg_rd_ack <= 0; reg_err <= 0; wc <= 0;
      end else if ((|reg_wr_ce) || (|reg_rd_ce)) begin
         ce_cyc <= ce_cyc + 1;
         seen_w <= seen_w | reg_wr_ce;
         seen_r <= seen_r | reg_rd_ce;
         if (reg_wr_ack || reg_rd_ack) begin
            if (reg_wr_ack && (|reg_wr_ce))
               for (int b = 0; b < 4; b++)
                  if (reg_be[b]) stub_regs[ce_idx(reg_wr_ce)][8*b +: 8] <= reg_wdata[8*b +: 8];
            reg_wr_ack <= 0; reg_rd_ack <= 0; reg_err <= 0;
         end else if (!stub_noack && wc == stub_lat) begin
            reg_wr_ack <= (|reg_wr_ce) ^ stub_wrong;
            reg_rd_ack <= (|reg_rd_ce) ^ stub_wrong;
            reg_err    <= stub_err;
         end
         wc <= wc + 1;
      end else begin
         reg_wr_ack <= 0; reg_rd_ack <= 0; reg_err <= 0; wc <= 0;
      end
   end

   // ---------------- reference model ----------------
   logic [31:0] exp_regs [NREG];
   initial for (int k = 0; k < NREG; k++) exp_regs[k] = '0;

   function automatic bit addr_hit(input logic [31:0] a);
      logic [31:0] o;
      o = (a - BASE) >> 2;
      return (a >= BASE) && (a <= HIGH) && (o < NREG);
   endfunction

   function automatic int addr_idx(input logic [31:0] a);
      logic [31:0] o;
      o = (a - BASE) >> 2;
      return int'(o);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] be);
      logic [31:0] r;
      r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- transaction task ----------------
   task automatic do_txn(input bit wr, input logic [31:0] addr, input logic [31:0] data,
                         input logic [3:0] strb, input int lat, input bit noack,
                         input bit err, input bit wrong, input int hold);
      bit          hit, acked;
      int          idx;
      logic [1:0]  exp_resp, got_resp;
      logic [31:0] exp_rd, got_rd;
      logic [NREG-1:0] exp_mask;
      int          exp_cyc;

      hit      = addr_hit(addr);
      idx      = hit ? addr_idx(addr) : 0;
      acked    = hit && !noack && !wrong;
      exp_resp = acked ? (err ? 2'b10 : 2'b00) : 2'b10;
      exp_mask = hit ? NREG'(1 << (NREG-1-idx)) : '0;
      exp_cyc  = !hit ? 0 : (acked ? lat + 2 : TMO);
      exp_rd   = acked ? exp_regs[idx] : 32'h0;

      @(negedge clk);
      stub_lat = lat; stub_noack = noack; stub_err = err; stub_wrong = wrong;
      if (wr) begin
         s_awaddr = addr; s_wdata = data; s_wstrb = strb;
         s_awvalid = 1; s_wvalid = 1;
         #1;
         while (!s_awready) begin @(negedge clk); #1; end
         @(posedge clk);
         @(negedge clk);
         s_awvalid = 0; s_wvalid = 0;
         while (!s_bvalid) @(negedge clk);
         got_resp = s_bresp;
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            // R10
            check(s_bvalid && s_bresp == got_resp, "R10 bresp hold", {30'd0, s_bresp},
                  {30'd0, got_resp});
         end
         s_bready = 1;
         @(posedge clk);
         @(negedge clk);
         s_bready = 0;
         // R6 R8 R9 R13
         check(got_resp == exp_resp, "R6/R8/R9 bresp", {30'd0, got_resp}, {30'd0, exp_resp});
         // R3 R9
         check(seen_w == exp_mask && seen_r == '0, "R3 write ce", {28'd0, seen_w},
               {28'd0, exp_mask});
         // R8
         check(ce_cyc == exp_cyc, "R8 write ce cycles", ce_cyc, exp_cyc);
         if (acked) exp_regs[idx] = merge(exp_regs[idx], data, strb);
      end else begin
         s_araddr = addr; s_arvalid = 1;
         #1;
         while (!s_arready) begin @(negedge clk); #1; end
         @(posedge clk);
         @(negedge clk);
         s_arvalid = 0;
         while (!s_rvalid) @(negedge clk);
         got_resp = s_rresp; got_rd = s_rdata;
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            // R10
            check(s_rvalid && s_rresp == got_resp && s_rdata == got_rd, "R10 rdata hold",
                  s_rdata, got_rd);
         end
         s_rready = 1;
         @(posedge clk);
         @(negedge clk);
         s_rready = 0;
         // R7 R8 R9
         check(got_resp == exp_resp, "R7/R8 rresp", {30'd0, got_resp}, {30'd0, exp_resp});
         check(got_rd == exp_rd, "R7/R8 rdata", got_rd, exp_rd);
         // R4
         check(seen_r == exp_mask && seen_w == '0, "R4 read ce", {28'd0, seen_r},
               {28'd0, exp_mask});
         check(ce_cyc == exp_cyc, "R8 read ce cycles", ce_cyc, exp_cyc);
      end
      stub_noack = 0; stub_err = 0; stub_wrong = 0;
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      report();
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 during reset
      check(!s_bvalid && !s_rvalid && reg_wr_ce == 0 && reg_rd_ce == 0, "R1 in reset",
            {s_bvalid, s_rvalid, 22'd0, reg_wr_ce, reg_rd_ce}, 32'd0);
      rstn = 1;
      @(negedge clk);
      // R1 after release
      check(s_bresp == 0 && s_rresp == 0 && s_rdata == 0 && !s_awready && !s_arready,
            "R1 after reset", s_rdata, 32'd0);

      // R2: a lone address valid gets no ready
      s_awvalid = 1; #1;
      check(!s_awready && !s_wready, "R2 lone awvalid", {31'd0, s_awready}, 32'd0);
      s_wvalid = 1; #1;
      check(s_awready && s_wready, "R2 paired valids", {30'd0, s_awready, s_wready}, 32'd3);
      // R11: write wins over a simultaneous read
      s_arvalid = 1; #1;
      check(s_awready && !s_arready, "R11 write priority", {30'd0, s_awready, s_arready},
            32'd2);
      s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;

      // directed: one write per register with full strobes, read back
      for (int k = 0; k < NREG; k++)
         do_txn(1, BASE + 32'(4*k), 32'h1111_0000 * (k + 1) + 32'(k), 4'hF, k, 0, 0, 0, 0);
      for (int k = 0; k < NREG; k++)
         do_txn(0, BASE + 32'(4*k), 0, 0, 1, 0, 0, 0, 1);

      // R5: lower two byte lanes only
      do_txn(1, BASE + 32'h4, 32'hAABB_CCDD, 4'b0011, 0, 0, 0, 0, 0);
      do_txn(0, BASE + 32'h4, 0, 0, 0, 0, 0, 0, 0);
      // R5: upper lane only
      do_txn(1, BASE + 32'h8, 32'h5500_0000, 4'b1000, 2, 0, 0, 0, 0);
      do_txn(0, BASE + 32'h8, 0, 0, 0, 0, 0, 0, 0);

      // R8: ack on the final allowed cycle still completes normally
      do_txn(1, BASE, 32'hCAFE_F00D, 4'hF, TMO - 2, 0, 0, 0, 2);
      do_txn(0, BASE, 0, 0, TMO - 2, 0, 0, 0, 0);
      // R8: no acknowledge at all
      do_txn(1, BASE + 32'hC, 32'hDEAD_BEEF, 4'hF, 0, 1, 0, 0, 0);
      do_txn(0, BASE + 32'hC, 0, 0, 0, 1, 0, 0, 2);
      // R6 R7: user error flag
      do_txn(1, BASE + 32'h4, 32'h0102_0304, 4'hF, 1, 0, 1, 0, 0);
      do_txn(0, BASE + 32'h4, 0, 0, 1, 0, 1, 0, 0);
      // R9: beyond register count, above and below the window
      do_txn(1, BASE + 32'h10, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0, 0);
      do_txn(0, BASE + 32'h10, 0, 0, 0, 0, 0, 0, 0);
      do_txn(1, HIGH + 32'h1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0, 0);
      do_txn(0, BASE - 32'h4, 0, 0, 0, 0, 0, 0, 0);
      // R13: wrong-kind acknowledge ignored, register untouched
      do_txn(1, BASE, 32'h7777_7777, 4'hF, 0, 0, 0, 1, 0);
      do_txn(0, BASE + 32'h4, 0, 0, 0, 0, 0, 1, 0);
      do_txn(0, BASE, 0, 0, 0, 0, 0, 0, 0);

      // R12: synchronous reset aborts an access in progress
      @(negedge clk);
      stub_noack = 1;
      s_awaddr = BASE + 32'h8; s_wdata = 32'h1234_5678; s_wstrb = 4'hF;
      s_awvalid = 1; s_wvalid = 1;
      @(posedge clk);
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0;
      @(negedge clk);
      check(reg_wr_ce == 4'b0010, "R12 write active", {28'd0, reg_wr_ce}, 32'h2);
      rstn = 0; #1;
      check(reg_wr_ce == 4'b0010, "R12 no change before edge", {28'd0, reg_wr_ce}, 32'h2);
      @(negedge clk);
      check(reg_wr_ce == 0 && !s_bvalid, "R12 dropped after edge",
            {27'd0, s_bvalid, reg_wr_ce}, 32'd0);
      rstn = 1; stub_noack = 0;
      @(negedge clk);
      do_txn(0, BASE + 32'h8, 0, 0, 0, 0, 0, 0, 0);

      // constrained random
      for (int n = 0; n < 90; n++) begin
         int          pick;
         logic [31:0] a;
         pick = int'($urandom % 7);
         case (pick)
            4:       a = BASE + 32'(4 * (NREG + int'($urandom % 8)));
            5:       a = HIGH + 32'(1 + 4 * int'($urandom % 4));
            6:       a = BASE - 32'(4 * (1 + int'($urandom % 4)));
            default: a = BASE + 32'(4 * pick);
         endcase
         do_txn(1'($urandom % 2), a, $urandom, 4'($urandom), int'($urandom % 6),
                ($urandom % 8) == 0, ($urandom % 6) == 0, 0, int'($urandom % 3));
      end

      // final readback of every register
      for (int k = 0; k < NREG; k++)
         do_txn(0, BASE + 32'(4*k), 0, 0, 0, 0, 0, 0, 0);

      report();
      $finish;
   end
endmodule